// File: doc/BRIEF.md
# Time-of-Day Calendar Counter

This block keeps wall-clock time and date: seconds, minutes, hours, weekday, day of month, month and a two-digit year. A one-cycle pulse on `sec_tick` moves the time forward by one second, and a carry runs through every field up to the year. The carry chain works on plain binary counters. The visible field registers hold the same values encoded in one of two ways, chosen by `bin_mode`: packed decimal (tens digit in bits 7:4, units digit in bits 3:0) or plain binary. Hours appear in 24-hour form, or in 12-hour form with an afternoon flag in bit 7.

Software sets the clock through a small write stream (`wr_valid`, `wr_sel`, `wr_data`), using the encoding that is currently selected. Raising `hold_set` freezes the visible registers so that several fields can be written as one consistent set. Dropping `hold_set` copies the whole register set into the running counter. Counting happens only while `osc_mode` holds the run code. The leap-year rule uses the full year, formed as `BASE_YEAR` plus the two-digit year.

Top module: `tod_calendar`

## Requirements
- R1: After reset the outputs read seconds 0, minutes 0, hours 0, weekday 1, day 1, month 1, year 0.
- R2: Each accepted tick adds one second. Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the date.
- R3: On each day carry the weekday counts 1..7 and wraps from 7 to 1.
- R4: On a day carry the day of month advances. When it would pass the month's length (31, 28/29, 31, 30, 31, 30, 31, 31, 30, 31, 30, 31 for months 1..12), it returns to 1 and the month advances.
- R5: February has 29 days when the full year (BASE_YEAR + two-digit year) is divisible by 400, or divisible by 4 and not by 100. Otherwise it has 28 days.
- R6: When the month would pass 12 it returns to 1, and the year advances modulo 100 (99 wraps to 0).
- R7: With `bin_mode`=1 every field reads as binary. With `bin_mode`=0 every field reads as packed decimal, tens in bits 7:4 and units in bits 3:0. A mode change re-encodes the outputs on the next clock edge.
- R8: With `h24_mode`=1 hours read 0..23. With `h24_mode`=0 bits 6:0 hold the hour modulo 12 in the selected encoding, and bit 7 is 1 for hours 12..23.
- R9: Ticks change the time only while `osc_mode` = 3'b010. Any other value leaves every field unchanged.
- R10: While `hold_set`=1 the outputs do not change, except for fields that are written. A write updates only the output of the field it targets and does not reach the counter. On the falling edge of `hold_set` the running time is loaded from the register contents.
- R11: `wr_ready` is always 1. A write with `wr_valid`=1 and `hold_set`=0 loads the running counter at once. `wr_sel` codes are: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year. Code 7 is ignored.
- R12: A tick updates the counter at the clock edge where it is seen, and the outputs at the next edge. A write in the same cycle as a tick takes priority, and that tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-second advance pulse, one cycle wide |
| osc_mode | input | 3 | Oscillator mode; 3'b010 lets time run |
| hold_set | input | 1 | Freeze outputs and gather writes; its fall loads the counter |
| bin_mode | input | 1 | 1 binary, 0 packed decimal |
| h24_mode | input | 1 | 1 for 24-hour, 0 for 12-hour with afternoon flag |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write acceptance, always high |
| wr_sel | input | 3 | Field select for the write |
| wr_data | input | 8 | Write value in the current encoding |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours (bit 7 afternoon in 12-hour mode) |
| wday_o | output | 8 | Weekday 1..7 |
| mday_o | output | 8 | Day of month |
| month_o | output | 8 | Month 1..12 |
| year_o | output | 8 | Two-digit year |

## Verification
The bench sweeps the last day of every month and the day before it, for four years, in both encodings, and compares the result against a calendar computed in the bench. A month-length table that is off by one day in either direction shows up as a wrong day or month after the tick. A second instance with `BASE_YEAR`=2100 exposes a design that treats every fourth year as leap and ignores the century rule. A run of more than an hour of ticks in 12-hour packed-decimal mode, and a second run that crosses noon in binary, catch digit-carry mistakes and a wrong afternoon flag. Separate checks cover five cases: a hold that leaks counting into the outputs, a release that fails to load the written fields, a halted oscillator mode that still counts, an ignored select code that corrupts a field, and a tick that overrides a write made in the same cycle.

// File: rtl/tod_pkg.sv
package tod_pkg;

  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 7;
  localparam int SEL_W      = $clog2(NUM_FIELDS + 1);

  localparam int F_SEC   = 0;
  localparam int F_MIN   = 1;
  localparam int F_HOUR  = 2;
  localparam int F_WDAY  = 3;
  localparam int F_MDAY  = 4;
  localparam int F_MONTH = 5;
  localparam int F_YEAR  = 6;

  localparam logic [2:0] OSC_RUN = 3'b010;

  typedef logic [FIELD_W-1:0] fld_t;
  typedef logic [NUM_FIELDS-1:0][FIELD_W-1:0] fvec_t;

  // year, month, mday, wday, hour, min, sec
  localparam fvec_t CNT_RESET = {8'd0, 8'd1, 8'd1, 8'd1, 8'd0, 8'd0, 8'd0};

  function automatic fld_t to_bcd(input fld_t v);
    fld_t tens;
    fld_t units;
    tens  = v / 8'd10;
    units = v % 8'd10;
    return {tens[3:0], units[3:0]};
  endfunction

  function automatic fld_t from_bcd(input fld_t d);
    fld_t hi;
    hi = {4'd0, d[7:4]};
    return hi * 8'd10 + {4'd0, d[3:0]};
  endfunction

  function automatic fld_t enc_field(input fld_t v, input logic bin);
    return bin ? v : to_bcd(v);
  endfunction

  function automatic fld_t dec_field(input fld_t d, input logic bin);
    return bin ? d : from_bcd(d);
  endfunction

  function automatic fld_t enc_hour(input fld_t h, input logic bin, input logic h24);
    fld_t r;
    if (h24) begin
      r = enc_field(h, bin);
    end else begin
      r    = enc_field(h % 8'd12, bin);
      r[7] = (h >= 8'd12);
    end
    return r;
  endfunction

  function automatic fld_t dec_hour(input fld_t d, input logic bin, input logic h24);
    fld_t v;
    v = dec_field({1'b0, d[6:0]}, bin);
    if (!h24 && d[7]) v = v + 8'd12;
    return v;
  endfunction

  function automatic logic is_leap(input fld_t yy, input int base);
    int full;
    full = base + int'(yy);
    return ((full % 4) == 0) && (((full % 100) != 0) || ((full % 400) == 0));
  endfunction

  function automatic fld_t days_in(input fld_t mon, input fld_t yy, input int base);
    case (mon)
      8'd2:                    return is_leap(yy, base) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
      default:                 return 8'd31;
    endcase
  endfunction

endpackage

// File: rtl/tod_codec.sv
// Converts between binary counter values and the visible field encoding.
module tod_codec
  import tod_pkg::*;
(
  input  fvec_t            cnt_vec,
  input  fvec_t            reg_vec,
  input  logic [SEL_W-1:0] wr_sel,
  input  fld_t             wr_data,
  input  logic             bin_mode,
  input  logic             h24_mode,
  output fvec_t            enc_vec,
  output fvec_t            dec_vec,
  output fld_t             wr_dec
);

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_fld
    if (gi == F_HOUR) begin : g_hr
      assign enc_vec[gi] = enc_hour(cnt_vec[gi], bin_mode, h24_mode);
      assign dec_vec[gi] = dec_hour(reg_vec[gi], bin_mode, h24_mode);
    end else begin : g_pl
      assign enc_vec[gi] = enc_field(cnt_vec[gi], bin_mode);
      assign dec_vec[gi] = dec_field(reg_vec[gi], bin_mode);
    end
  end

  // A single write is decoded on its own so it can load the counter directly.
  assign wr_dec = (wr_sel == SEL_W'(F_HOUR)) ? dec_hour(wr_data, bin_mode, h24_mode)
                                             : dec_field(wr_data, bin_mode);

endmodule

// File: rtl/tod_counter.sv
// Binary time/date counter with full carry chain.
module tod_counter
  import tod_pkg::*;
#(
  parameter int BASE_YEAR = 2000
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             load_all,
  input  fvec_t            load_vec,
  input  logic             load_one,
  input  logic [SEL_W-1:0] load_sel,
  input  fld_t             load_val,
  output fvec_t            cnt_q
);

  fld_t  s_n, m_n, h_n, wd_n, md_n, mo_n, y_n, mlen;
  fvec_t adv_vec;

  always_comb begin
    mlen = days_in(cnt_q[F_MONTH], cnt_q[F_YEAR], BASE_YEAR);
    s_n  = cnt_q[F_SEC] + 8'd1;
    m_n  = cnt_q[F_MIN];
    h_n  = cnt_q[F_HOUR];
    wd_n = cnt_q[F_WDAY];
    md_n = cnt_q[F_MDAY];
    mo_n = cnt_q[F_MONTH];
    y_n  = cnt_q[F_YEAR];
    if (s_n >= 8'd60) begin
      s_n = 8'd0;
      m_n = m_n + 8'd1;
      if (m_n >= 8'd60) begin
        m_n = 8'd0;
        h_n = h_n + 8'd1;
        if (h_n >= 8'd24) begin
          h_n  = 8'd0;
          wd_n = wd_n + 8'd1;
          if (wd_n > 8'd7 || wd_n == 8'd0) wd_n = 8'd1;
          md_n = md_n + 8'd1;
          if (md_n == 8'd0) begin
            md_n = 8'd1;
          end else if (md_n > mlen) begin
            md_n = 8'd1;
            mo_n = mo_n + 8'd1;
            if (mo_n > 8'd12 || mo_n == 8'd0) begin
              mo_n = 8'd1;
              y_n  = y_n + 8'd1;
              if (y_n >= 8'd100) y_n = 8'd0;
            end
          end
        end
      end
    end
    adv_vec = {y_n, mo_n, md_n, wd_n, h_n, m_n, s_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_RESET;
    end else if (load_all) begin
      cnt_q <= load_vec;
    end else if (load_one) begin
      for (int i = 0; i < NUM_FIELDS; i++) begin
        if (load_sel == SEL_W'(i)) cnt_q[i] <= load_val;
      end
    end else if (adv) begin
      cnt_q <= adv_vec;
    end
  end

endmodule

// File: rtl/tod_regbank.sv
// Visible field registers: writes take priority over refresh from the counter.
module tod_regbank
  import tod_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  fld_t             wr_data,
  input  logic             refresh,
  input  fvec_t            fresh_vec,
  output fvec_t            reg_q
);

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[gi] <= CNT_RESET[gi];
      end else if (wr_en && wr_sel == SEL_W'(gi)) begin
        reg_q[gi] <= wr_data;
      end else if (refresh) begin
        reg_q[gi] <= fresh_vec[gi];
      end
    end
  end

endmodule

// File: rtl/tod_calendar.sv
module tod_calendar
  import tod_pkg::*;
#(
  parameter int BASE_YEAR = 2000
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_tick,
  input  logic [2:0]         osc_mode,
  input  logic               hold_set,
  input  logic               bin_mode,
  input  logic               h24_mode,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [FIELD_W-1:0] wr_data,
  output logic [FIELD_W-1:0] sec_o,
  output logic [FIELD_W-1:0] min_o,
  output logic [FIELD_W-1:0] hour_o,
  output logic [FIELD_W-1:0] wday_o,
  output logic [FIELD_W-1:0] mday_o,
  output logic [FIELD_W-1:0] month_o,
  output logic [FIELD_W-1:0] year_o
);

  logic  set_q;
  logic  wr_fire, load_one, load_all, adv, refresh;
  fvec_t cnt_vec, reg_vec, enc_vec, dec_vec;
  fld_t  wr_dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) set_q <= 1'b0;
    else        set_q <= hold_set;
  end

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && (wr_sel < SEL_W'(NUM_FIELDS));
  assign load_all = set_q && !hold_set;
  assign load_one = wr_fire && !hold_set && !load_all;
  assign adv      = sec_tick && (osc_mode == OSC_RUN) && !load_one && !load_all;
  assign refresh  = !hold_set && !set_q;

  tod_codec u_codec (
    .cnt_vec  (cnt_vec),
    .reg_vec  (reg_vec),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .bin_mode (bin_mode),
    .h24_mode (h24_mode),
    .enc_vec  (enc_vec),
    .dec_vec  (dec_vec),
    .wr_dec   (wr_dec)
  );

  tod_counter #(.BASE_YEAR(BASE_YEAR)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .load_all (load_all),
    .load_vec (dec_vec),
    .load_one (load_one),
    .load_sel (wr_sel),
    .load_val (wr_dec),
    .cnt_q    (cnt_vec)
  );

  tod_regbank u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_fire),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .refresh   (refresh),
    .fresh_vec (enc_vec),
    .reg_q     (reg_vec)
  );

  assign sec_o   = reg_vec[F_SEC];
  assign min_o   = reg_vec[F_MIN];
  assign hour_o  = reg_vec[F_HOUR];
  assign wday_o  = reg_vec[F_WDAY];
  assign mday_o  = reg_vec[F_MDAY];
  assign month_o = reg_vec[F_MONTH];
  assign year_o  = reg_vec[F_YEAR];

endmodule

// File: rtl/tod_calendar_chk.sv
module tod_calendar_chk
  import tod_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       hold_set,
  input logic       wr_valid,
  input logic [2:0] osc_mode,
  input logic       h24_mode,
  input logic       adv,
  input logic       load_one,
  input logic       load_all,
  input logic       refresh,
  input logic       wr_fire,
  input fvec_t      cnt_vec,
  input fvec_t      reg_vec
);

  p_sec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt_vec[F_SEC] < 8'd59) |=> (cnt_vec[F_SEC] == $past(cnt_vec[F_SEC]) + 8'd1));

  p_wday_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt_vec[F_WDAY] >= 8'd1 && cnt_vec[F_WDAY] <= 8'd7)
    |=> (cnt_vec[F_WDAY] >= 8'd1 && cnt_vec[F_WDAY] <= 8'd7));

  p_mday_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt_vec[F_MDAY] >= 8'd1 && cnt_vec[F_MDAY] <= 8'd31)
    |=> (cnt_vec[F_MDAY] >= 8'd1 && cnt_vec[F_MDAY] <= 8'd31));

  p_month_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt_vec[F_MONTH] >= 8'd1 && cnt_vec[F_MONTH] <= 8'd12)
    |=> (cnt_vec[F_MONTH] >= 8'd1 && cnt_vec[F_MONTH] <= 8'd12));

  p_pm_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!h24_mode && refresh && !wr_fire)
    |=> (reg_vec[F_HOUR][7] == ($past(cnt_vec[F_HOUR]) >= 8'd12)));

  p_osc_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_mode != OSC_RUN && !load_one && !load_all) |=> $stable(cnt_vec));

  p_hold_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_set && !wr_valid) |=> $stable(reg_vec));

endmodule

bind tod_calendar tod_calendar_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hold_set (hold_set),
  .wr_valid (wr_valid),
  .osc_mode (osc_mode),
  .h24_mode (h24_mode),
  .adv      (adv),
  .load_one (load_one),
  .load_all (load_all),
  .refresh  (refresh),
  .wr_fire  (wr_fire),
  .cnt_vec  (cnt_vec),
  .reg_vec  (reg_vec)
);

// File: tb/sim_tod_calendar.sv
module sim_tod_calendar;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic [2:0] osc_mode = 3'b010;
  logic       hold_set = 1'b0;
  logic       bin_mode = 1'b0;
  logic       h24_mode = 1'b1;
  logic       wr_valid = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic       wr_ready, wr_ready1;
  logic [7:0] o_sec, o_min, o_hour, o_wday, o_mday, o_mon, o_year;
  logic [7:0] x_sec, x_min, x_hour, x_wday, x_mday, x_mon, x_year;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_calendar u0 (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .osc_mode(osc_mode),
    .hold_set(hold_set), .bin_mode(bin_mode), .h24_mode(h24_mode),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_sel(wr_sel), .wr_data(wr_data),
    .sec_o(o_sec), .min_o(o_min), .hour_o(o_hour), .wday_o(o_wday),
    .mday_o(o_mday), .month_o(o_mon), .year_o(o_year)
  );

  // Second copy with a century base that is not a leap year.
  tod_calendar #(.BASE_YEAR(2100)) u1 (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .osc_mode(osc_mode),
    .hold_set(hold_set), .bin_mode(bin_mode), .h24_mode(h24_mode),
    .wr_valid(wr_valid), .wr_ready(wr_ready1), .wr_sel(wr_sel), .wr_data(wr_data),
    .sec_o(x_sec), .min_o(x_min), .hour_o(x_hour), .wday_o(x_wday),
    .mday_o(x_mday), .month_o(x_mon), .year_o(x_year)
  );

  function automatic int enc(input int v);
    return bin_mode ? v : (((v / 10) * 16) + (v % 10));
  endfunction

  function automatic int enc_hr(input int h);
    if (h24_mode) return enc(h);
    return enc(h % 12) + ((h >= 12) ? 128 : 0);
  endfunction

  function automatic int mlen(input int mo, input int yr);
    bit lp;
    lp = (yr % 400 == 0) || ((yr % 4 == 0) && (yr % 100 != 0));
    if (mo == 2) return lp ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic check_time(input string req, input int s, input int m, input int h,
                            input int wd, input int md, input int mo, input int y);
    chk(req, "sec",   int'(o_sec),  enc(s));
    chk(req, "min",   int'(o_min),  enc(m));
    chk(req, "hour",  int'(o_hour), enc_hr(h));
    chk(req, "wday",  int'(o_wday), enc(wd));
    chk(req, "mday",  int'(o_mday), enc(md));
    chk(req, "month", int'(o_mon),  enc(mo));
    chk(req, "year",  int'(o_year), enc(y));
  endtask

  task automatic put(input int sel, input int data);
    wr_valid = 1'b1;
    wr_sel   = 3'(sel);
    wr_data  = 8'(data);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic load_time(input int s, input int m, input int h,
                           input int wd, input int md, input int mo, input int y);
    hold_set = 1'b1;
    put(0, enc(s)); put(1, enc(m)); put(2, enc_hr(h)); put(3, enc(wd));
    put(4, enc(md)); put(5, enc(mo)); put(6, enc(y));
    hold_set = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic tick();
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int s, m, h, nd, nmo, ny, d, d1, ld, ymap[4];
    ymap = '{0, 1, 4, 99};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset contents
    check_time("R1", 0, 0, 0, 1, 1, 1, 0);
    chk("R11", "wr_ready", int'(wr_ready), 1);

    // R4 R5 R6 R7: month ends over several years, both encodings
    for (int b = 0; b < 2; b++) begin
      bin_mode = b[0];
      h24_mode = 1'b1;
      for (int mo = 1; mo <= 12; mo++) begin
        for (int yi = 0; yi < 4; yi++) begin
          for (int k = 0; k < 2; k++) begin
            string tg;
            int y;
            y  = ymap[yi];
            d  = mlen(mo, 2000 + y);
            tg = (mo == 2) ? "R5" : ((mo == 12) ? "R6" : "R4");
            ld = (k == 0) ? d - 1 : d;
            load_time(59, 59, 23, 3, ld, mo, y);
            tick();
            nd = ld + 1; nmo = mo; ny = y;
            if (nd > d) begin
              nd = 1; nmo = mo + 1;
              if (nmo > 12) begin nmo = 1; ny = (y + 1) % 100; end
            end
            check_time(tg, 0, 0, 0, 4, nd, nmo, ny);
            if (mo == 2) begin
              d1 = mlen(2, 2100 + y);
              nd = ld + 1; nmo = 2;
              if (nd > d1) begin nd = 1; nmo = 3; end
              chk("R5", "century mday",  int'(x_mday), enc(nd));
              chk("R5", "century month", int'(x_mon),  enc(nmo));
            end
          end
        end
      end
    end

    // R2 R3 R6 R8: over an hour in 12-hour packed decimal, across midnight and new year
    bin_mode = 1'b0;
    h24_mode = 1'b0;
    load_time(0, 0, 23, 7, 31, 12, 99);
    s = 0; m = 0; h = 23;
    for (int t = 0; t < 3605; t++) begin
      tick();
      s++;
      if (s == 60) begin s = 0; m++; end
      if (m == 60) begin m = 0; h++; end
      if (h == 24) h = 0;
      if (h == 23) check_time("R2", s, m, h, 7, 31, 12, 99);
      else         check_time("R8", s, m, h, 1, 1, 1, 0);
    end
    check_time("R3/R6", 5, 0, 0, 1, 1, 1, 0);

    // R8 R7: crossing noon in binary 12-hour form
    bin_mode = 1'b1;
    load_time(30, 59, 11, 2, 10, 6, 24);
    s = 30; m = 59; h = 11;
    for (int t = 0; t < 65; t++) begin
      tick();
      s++;
      if (s == 60) begin s = 0; m++; end
      if (m == 60) begin m = 0; h++; end
      check_time("R8", s, m, h, 2, 10, 6, 24);
    end

    // R7: switching the encoding re-encodes the outputs
    h24_mode = 1'b1;
    load_time(45, 37, 19, 5, 28, 8, 58);
    bin_mode = 1'b0;
    @(negedge clk);
    check_time("R7", 45, 37, 19, 5, 28, 8, 58);
    bin_mode = 1'b1;
    @(negedge clk);
    check_time("R7", 45, 37, 19, 5, 28, 8, 58);

    // R9: halted oscillator codes
    osc_mode = 3'b110;
    tick();
    check_time("R9", 45, 37, 19, 5, 28, 8, 58);
    osc_mode = 3'b000;
    tick();
    check_time("R9", 45, 37, 19, 5, 28, 8, 58);
    osc_mode = 3'b010;
    tick();
    check_time("R9", 46, 37, 19, 5, 28, 8, 58);

    // R10: hold freezes the outputs, a write shows, release loads the registers
    hold_set = 1'b1;
    @(negedge clk);
    tick(); tick(); tick();
    check_time("R10", 46, 37, 19, 5, 28, 8, 58);
    put(1, enc(12));
    check_time("R10", 46, 12, 19, 5, 28, 8, 58);
    hold_set = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_time("R10", 46, 12, 19, 5, 28, 8, 58);
    tick();
    check_time("R10", 47, 12, 19, 5, 28, 8, 58);

    // R11: direct write loads the counter; select code 7 has no effect
    put(1, enc(42));
    @(negedge clk);
    check_time("R11", 47, 42, 19, 5, 28, 8, 58);
    tick();
    check_time("R11", 48, 42, 19, 5, 28, 8, 58);
    put(7, 8'h55);
    @(negedge clk);
    check_time("R11", 48, 42, 19, 5, 28, 8, 58);

    // R12: write wins over a tick in the same cycle
    wr_valid = 1'b1; wr_sel = 3'd0; wr_data = 8'(enc(20)); sec_tick = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; sec_tick = 1'b0;
    @(negedge clk);
    check_time("R12", 20, 42, 19, 5, 28, 8, 58);
    // R12: output changes only one edge after the counter
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    chk("R12", "sec before refresh", int'(o_sec), enc(20));
    @(negedge clk);
    chk("R12", "sec after refresh", int'(o_sec), enc(21));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule